// File: doc/BRIEF.md
# Shared-Engine Drive Link Serializer

This block carries sector data between a word-wide buffer memory and four single-bit drive links. Two conversion engines serve all four links. Each engine runs one transfer at a time. A switching matrix attaches it to whichever drive the transfer names.

Each transfer carries four settings: the drive index, the direction, and a word count, along with a start strobe. In the write direction, the engine takes 16-bit words over a valid/ready handshake and places them on the chosen drive's output line, one bit per clock. In the read direction, the engine samples the chosen drive's input line on every clock. It packs each group of sixteen bits into a word and presents that word for one cycle. A done strobe marks the end of the last word. Only one engine may use a drive at any moment. A request that would share a drive is refused and reported with an error strobe. A request for zero words is refused in the same way.

Top module: `disk_serdes_switch`

## Requirements
- R1: After a synchronous active-low reset, every drive output line is 0, and the busy, done, error, write-ready and read-valid outputs of both engines are 0.
- R2: In a write, a word accepted at a clock edge (write valid and write ready both high) appears on the selected drive's output line from the next cycle on, most-significant bit first, one bit per cycle for 16 cycles.
- R3: During the last bit of a word that is not the final word, write ready is high, so a word offered then follows with no gap. If no word is offered, the line holds 0 until the next word is accepted.
- R4: In a read, the selected drive's input line is sampled at each clock edge, starting with the first edge after the start edge. After every 16th sample, read valid is high for exactly one cycle with the word, and the earliest sample is the most-significant bit.
- R5: A transfer moves exactly the programmed number of words. The done output is high for one cycle, in the cycle after the last bit has been on the line (write) or sampled (read). Busy is low in that same cycle.
- R6: The drive select is a 2-bit binary drive index, and the direction bit is 1 for write and 0 for read. Both are captured, together with the word count, at the start edge. Changes to the command inputs during a transfer have no effect on it.
- R7: A drive output line that no write transfer is using stays at 0. This includes a drive that is being read.
- R8: A start naming a drive held by the other busy engine is refused. The error output is high for one cycle after the start edge, and the engine stays idle.
- R9: If both engines start on the same drive in the same cycle, engine 0 is granted and engine 1 is refused with an error strobe.
- R10: A start with a word count of 0 is refused with an error strobe, and the engine stays idle.
- R11: A start to an engine that is already busy is ignored. No error is raised, and the running transfer keeps its drive.
- R12: Both engines run independent transfers on different drives at the same time, without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 2 | Per-engine start strobe |
| cmd_drive | input | 4 | Per-engine 2-bit drive index (engine e at bits 2e+1:2e) |
| cmd_write | input | 2 | Per-engine direction, 1 = write to drive |
| cmd_words | input | 16 | Per-engine 8-bit word count (engine e at bits 8e+7:8e) |
| wr_valid | input | 2 | Per-engine write word offered |
| wr_data | input | 32 | Per-engine write word (engine e at bits 16e+15:16e) |
| wr_ready | output | 2 | Per-engine write word can be taken |
| rd_valid | output | 2 | Per-engine read word strobe |
| rd_data | output | 32 | Per-engine read word |
| xfer_busy | output | 2 | Engine holds a transfer |
| xfer_done | output | 2 | One-cycle end-of-transfer strobe |
| xfer_err | output | 2 | One-cycle refused-start strobe |
| drive_txd | output | 4 | Serial data toward each drive |
| drive_rxd | input | 4 | Serial data from each drive |

## Verification
The bench sweeps every engine, drive and direction with word counts of one to three. It then runs paired transfers on every pair of distinct drives. The riskiest case is the word boundary. A design that opens write ready late inserts an idle bit between words. A design that mis-times the read capture shifts every word by one bit. A design that drops the count check sends one word too many or too few and moves the done strobe. An inserted gap must show as zeros, not repeated data. Refusal is checked in three forms: the drive is held, both engines start on it in the same cycle, or the count is zero. A design with a loose arbiter would let two engines drive one line, or would raise an error on a start to a busy engine. The command inputs are scrambled while transfers run, to catch a design that does not latch them.

// File: rtl/dss_pkg.sv
// Package: shared state encoding for the drive-link conversion engines.
// Assumes nothing beyond being compiled before the modules that import it.
package dss_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_FETCH  = 2'd1,
        ENG_SHIFT  = 2'd2,
        ENG_GATHER = 2'd3
    } eng_state_e;

endpackage

// File: rtl/dss_engine.sv
// One conversion engine. On a grant it captures drive, direction and word
// count. Write: takes words over valid/ready and shifts them out MSB first.
// Read: samples its serial input every clock and emits a word per 16 bits.
// Assumes the grant arrives only while the engine is idle, and that the
// consumer always takes a read word in the cycle it is strobed.
module dss_engine
    import dss_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [SEL_W-1:0]  go_drv,
    input  logic              go_write,
    input  logic [CNT_W-1:0]  go_words,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              busy,
    output logic              done,
    output logic [SEL_W-1:0]  cur_drv,
    output logic              cur_write
);

    localparam int              BIT_W    = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    eng_state_e        state;
    logic [SEL_W-1:0]  drv_q;
    logic              dir_q;
    logic [CNT_W-1:0]  left_q;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] rd_data_q;
    logic              rd_valid_q;
    logic              done_q;
    logic              last_word;

    // Final word of the transfer is the one in flight.
    assign last_word = (left_q == CNT_W'(1));

    // Transfer sequencing, shifting and word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ENG_IDLE;
            drv_q      <= '0;
            dir_q      <= 1'b0;
            left_q     <= '0;
            bit_q      <= '0;
            shreg      <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            done_q     <= 1'b0;
            unique case (state)
                ENG_IDLE: begin
                    if (go) begin
                        drv_q  <= go_drv;
                        dir_q  <= go_write;
                        left_q <= go_words;
                        bit_q  <= LAST_BIT;
                        state  <= go_write ? ENG_FETCH : ENG_GATHER;
                    end
                end
                ENG_FETCH: begin
                    if (wr_valid) begin
                        shreg <= wr_data;
                        bit_q <= LAST_BIT;
                        state <= ENG_SHIFT;
                    end
                end
                ENG_SHIFT: begin
                    shreg <= shreg << 1;
                    if (bit_q == '0) begin
                        left_q <= left_q - CNT_W'(1);
                        if (last_word) begin
                            state  <= ENG_IDLE;
                            done_q <= 1'b1;
                        end else if (wr_valid) begin
                            shreg <= wr_data;
                            bit_q <= LAST_BIT;
                        end else begin
                            state <= ENG_FETCH;
                        end
                    end else begin
                        bit_q <= bit_q - BIT_W'(1);
                    end
                end
                ENG_GATHER: begin
                    shreg <= {shreg[WORD_W-2:0], ser_in};
                    if (bit_q == '0) begin
                        rd_data_q  <= {shreg[WORD_W-2:0], ser_in};
                        rd_valid_q <= 1'b1;
                        bit_q      <= LAST_BIT;
                        left_q     <= left_q - CNT_W'(1);
                        if (last_word) begin
                            state  <= ENG_IDLE;
                            done_q <= 1'b1;
                        end
                    end else begin
                        bit_q <= bit_q - BIT_W'(1);
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Ready while waiting for a word, or on the last bit when more follow.
    assign wr_ready  = (state == ENG_FETCH) ||
                       ((state == ENG_SHIFT) && (bit_q == '0) && !last_word);
    assign ser_out   = (state == ENG_SHIFT) && shreg[WORD_W-1];
    assign busy      = (state != ENG_IDLE);
    assign done      = done_q;
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
    assign cur_drv   = drv_q;
    assign cur_write = dir_q;

    // R6: captured settings hold steady for the whole transfer.
    assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(drv_q) && $stable(dir_q)));

    // R5: the end strobe coincides with the engine being free.
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: read words only ever come from a read transfer.
    assert_rdvalid_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !dir_q);

    // R2: a write word is accepted only into a running write transfer.
    assert_ready_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (busy && dir_q));

endmodule

// File: rtl/dss_arbiter.sv
// Start arbiter. It grants a start only to an idle engine with a nonzero
// count whose drive is neither held by a busy engine nor granted to a
// lower-numbered engine in the same cycle. A start that reaches an idle
// engine and is not granted raises a one-cycle error. A start to a busy
// engine is dropped silently.
// Assumes busy/held_drv come straight from the engines.
module dss_arbiter #(
    parameter int NUM_ENG = 2,
    parameter int SEL_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_ENG-1:0]       start,
    input  logic [NUM_ENG-1:0]       cnt_zero,
    input  logic [NUM_ENG-1:0]       busy,
    input  logic [NUM_ENG*SEL_W-1:0] req_drv,
    input  logic [NUM_ENG*SEL_W-1:0] held_drv,
    output logic [NUM_ENG-1:0]       grant,
    output logic [NUM_ENG-1:0]       err
);

    logic [NUM_ENG-1:0] err_q;

    // Grant in index order; lower index wins a shared drive.
    always_comb begin
        logic ok;
        grant = '0;
        for (int e = 0; e < NUM_ENG; e++) begin
            ok = start[e] && !busy[e] && !cnt_zero[e];
            for (int o = 0; o < NUM_ENG; o++) begin
                if (o != e && busy[o] &&
                    held_drv[o*SEL_W +: SEL_W] == req_drv[e*SEL_W +: SEL_W])
                    ok = 1'b0;
                if (o < e && grant[o] &&
                    req_drv[o*SEL_W +: SEL_W] == req_drv[e*SEL_W +: SEL_W])
                    ok = 1'b0;
            end
            grant[e] = ok;
        end
    end

    // Register refusal strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= start & ~busy & ~grant;
    end

    assign err = err_q;

    generate
        for (genvar e = 0; e < NUM_ENG; e++) begin : g_chk
            // R8: a refused engine has not started.
            assert_refused_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
                err[e] |-> !busy[e]);
        end
    endgenerate

endmodule

// File: rtl/dss_xbar.sv
// Switching matrix between engines and drive links. Each drive line is the
// OR of the engines writing to it, which is at most one. Each engine reads
// the input line of the drive it holds.
// Assumes the arbiter keeps drive ownership exclusive.
module dss_xbar #(
    parameter int NUM_ENG = 2,
    parameter int NUM_DRV = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_ENG*SEL_W-1:0] eng_drv,
    input  logic [NUM_ENG-1:0]       eng_talk,
    input  logic [NUM_ENG-1:0]       eng_txd,
    input  logic [NUM_DRV-1:0]       drive_rxd,
    output logic [NUM_DRV-1:0]       drive_txd,
    output logic [NUM_ENG-1:0]       eng_rxd
);

    // Route writing engines onto drive lines; idle lines stay 0.
    always_comb begin
        drive_txd = '0;
        for (int d = 0; d < NUM_DRV; d++) begin
            for (int e = 0; e < NUM_ENG; e++) begin
                if (eng_talk[e] && eng_drv[e*SEL_W +: SEL_W] == SEL_W'(d))
                    drive_txd[d] = drive_txd[d] | eng_txd[e];
            end
        end
    end

    // Route each drive's input to the engine holding it.
    always_comb begin
        for (int e = 0; e < NUM_ENG; e++)
            eng_rxd[e] = drive_rxd[eng_drv[e*SEL_W +: SEL_W]];
    end

endmodule

// File: rtl/disk_serdes_switch.sv
// Top: two conversion engines shared among four serial drive links.
// Per engine, a start strobe with drive index, direction and word count
// launches one transfer; the arbiter enforces exclusive drive use.
// Assumes read words are consumed when strobed.
module disk_serdes_switch #(
    parameter int NUM_ENG = 2,
    parameter int NUM_DRV = 4,
    parameter int WORD_W  = 16,
    parameter int CNT_W   = 8,
    localparam int SEL_W  = $clog2(NUM_DRV)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_ENG-1:0]        cmd_start,
    input  logic [NUM_ENG*SEL_W-1:0]  cmd_drive,
    input  logic [NUM_ENG-1:0]        cmd_write,
    input  logic [NUM_ENG*CNT_W-1:0]  cmd_words,
    input  logic [NUM_ENG-1:0]        wr_valid,
    input  logic [NUM_ENG*WORD_W-1:0] wr_data,
    output logic [NUM_ENG-1:0]        wr_ready,
    output logic [NUM_ENG-1:0]        rd_valid,
    output logic [NUM_ENG*WORD_W-1:0] rd_data,
    output logic [NUM_ENG-1:0]        xfer_busy,
    output logic [NUM_ENG-1:0]        xfer_done,
    output logic [NUM_ENG-1:0]        xfer_err,
    output logic [NUM_DRV-1:0]        drive_txd,
    input  logic [NUM_DRV-1:0]        drive_rxd
);

    logic [NUM_ENG-1:0]       grant;
    logic [NUM_ENG-1:0]       cnt_zero;
    logic [NUM_ENG*SEL_W-1:0] held_drv;
    logic [NUM_ENG-1:0]       eng_dir;
    logic [NUM_ENG-1:0]       eng_talk;
    logic [NUM_ENG-1:0]       eng_txd;
    logic [NUM_ENG-1:0]       eng_rxd;

    generate
        for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
            // Zero-count detection per engine.
            assign cnt_zero[e] = (cmd_words[e*CNT_W +: CNT_W] == '0);

            dss_engine #(
                .WORD_W(WORD_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
            ) u_eng (
                .clk      (clk),
                .rst_n    (rst_n),
                .go       (grant[e]),
                .go_drv   (cmd_drive[e*SEL_W +: SEL_W]),
                .go_write (cmd_write[e]),
                .go_words (cmd_words[e*CNT_W +: CNT_W]),
                .wr_valid (wr_valid[e]),
                .wr_data  (wr_data[e*WORD_W +: WORD_W]),
                .wr_ready (wr_ready[e]),
                .rd_valid (rd_valid[e]),
                .rd_data  (rd_data[e*WORD_W +: WORD_W]),
                .ser_in   (eng_rxd[e]),
                .ser_out  (eng_txd[e]),
                .busy     (xfer_busy[e]),
                .done     (xfer_done[e]),
                .cur_drv  (held_drv[e*SEL_W +: SEL_W]),
                .cur_write(eng_dir[e])
            );

            // An engine drives a line only while running a write.
            assign eng_talk[e] = xfer_busy[e] & eng_dir[e];
        end
    endgenerate

    dss_arbiter #(.NUM_ENG(NUM_ENG), .SEL_W(SEL_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cmd_start),
        .cnt_zero(cnt_zero),
        .busy    (xfer_busy),
        .req_drv (cmd_drive),
        .held_drv(held_drv),
        .grant   (grant),
        .err     (xfer_err)
    );

    dss_xbar #(.NUM_ENG(NUM_ENG), .NUM_DRV(NUM_DRV), .SEL_W(SEL_W)) u_xbar (
        .eng_drv  (held_drv),
        .eng_talk (eng_talk),
        .eng_txd  (eng_txd),
        .drive_rxd(drive_rxd),
        .drive_txd(drive_txd),
        .eng_rxd  (eng_rxd)
    );

    generate
        for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv_chk
            logic [NUM_ENG-1:0] on_drive;
            for (genvar e = 0; e < NUM_ENG; e++) begin : g_own
                assign on_drive[e] = xfer_busy[e] &&
                                     held_drv[e*SEL_W +: SEL_W] == SEL_W'(d);
            end
            // R8: no two busy engines ever hold one drive.
            assert_one_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(on_drive));
            // R7: a line with no writer stays at 0.
            assert_idle_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ((on_drive & eng_dir) == '0) |-> !drive_txd[d]);
        end
    endgenerate

endmodule

// File: tb/disk_serdes_switch_test.sv
module disk_serdes_switch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_start = '0;
    logic [3:0]  cmd_drive = '0;
    logic [1:0]  cmd_write = '0;
    logic [15:0] cmd_words = '0;
    logic [1:0]  wr_valid = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  wr_ready;
    logic [1:0]  rd_valid;
    logic [31:0] rd_data;
    logic [1:0]  xfer_busy;
    logic [1:0]  xfer_done;
    logic [1:0]  xfer_err;
    logic [3:0]  drive_txd;
    logic [3:0]  drive_rxd = '0;

    disk_serdes_switch uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_drive(cmd_drive),
        .cmd_write(cmd_write), .cmd_words(cmd_words), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
        .xfer_err(xfer_err), .drive_txd(drive_txd), .drive_rxd(drive_rxd)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_cmp = 0;
    int n_bad = 0;

    // Bench-side transfer model, one slot per engine.
    bit          act [2];
    bit          isw [2];
    int          drv [2];
    int          cnt [2];
    logic [15:0] wds [2][8];
    int          widx [2];
    int          epos [2];
    int          gapc [2];
    int          rbit [2];
    bit          acc [2];
    bit          lastf [2];
    logic [15:0] eword [2];

    task automatic chk(string req, int actual, int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, actual, expected, $time);
        end
    endtask

    function automatic logic [15:0] mk_word(int tag, int k);
        return 16'((tag * 40503 + k * 27183 + 4660) ^ (tag << 7) ^ (k << 11));
    endfunction

    task automatic do_reset();
        cmd_start = '0; cmd_drive = '0; cmd_write = '0; cmd_words = '0;
        wr_valid = '0; wr_data = '0; drive_rxd = '0;
        for (int e = 0; e < 2; e++) act[e] = 0;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic launch(int e, bit w, int d, int c, int gap, int tag);
        act[e] = 1; isw[e] = w; drv[e] = d; cnt[e] = c; gapc[e] = gap;
        widx[e] = 0; epos[e] = 0; rbit[e] = 0; lastf[e] = 0; acc[e] = 0;
        for (int k = 0; k < 8; k++) wds[e][k] = mk_word(tag, k);
        cmd_start[e] = 1'b1;
        cmd_drive[e*2 +: 2] = 2'(d);
        cmd_write[e] = w;
        cmd_words[e*8 +: 8] = 8'(c);
    endtask

    // Check outputs at a falling edge, then set inputs for the next edge.
    task automatic observe_and_drive();
        bit used [4];
        for (int d = 0; d < 4; d++) used[d] = 0;
        for (int e = 0; e < 2; e++) begin
            if (!act[e]) continue;
            if (isw[e]) begin
                used[drv[e]] = 1;
                // R2,R6: bit on the originally selected line, MSB first
                chk("R2,R6 line bit", drive_txd[drv[e]],
                    (epos[e] > 0) ? int'(eword[e][epos[e]-1]) : 0);
                if (epos[e] == 1 && widx[e] < cnt[e] && gapc[e] == 0)
                    chk("R3 ready on last bit", wr_ready[e], 1);
                chk("R5 write done", xfer_done[e], lastf[e]);
                if (lastf[e]) begin
                    chk("R5 busy low at done", xfer_busy[e], 0);
                    act[e] = 0;
                end
            end else begin
                bit vexp;
                vexp = (rbit[e] > 0) && (rbit[e] % 16 == 0);
                chk("R4 read valid", rd_valid[e], vexp);
                if (vexp)
                    chk("R4 read word", rd_data[e*16 +: 16], wds[e][rbit[e]/16 - 1]);
                chk("R5 read done", xfer_done[e], rbit[e] == 16 * cnt[e]);
                if (rbit[e] == 16 * cnt[e]) begin
                    chk("R5 busy low at done", xfer_busy[e], 0);
                    act[e] = 0;
                end
            end
        end
        for (int d = 0; d < 4; d++)
            if (!used[d]) chk("R7 idle line", drive_txd[d], 0);
        drive_rxd = '0;
        for (int e = 0; e < 2; e++) begin
            acc[e] = 0;
            if (act[e] && isw[e]) begin
                wr_valid[e] = (widx[e] < cnt[e]) && !(widx[e] == 1 && gapc[e] > 0);
                wr_data[e*16 +: 16] = wds[e][widx[e] < 8 ? widx[e] : 0];
                acc[e] = wr_ready[e] && wr_valid[e];
                if (widx[e] == 1 && gapc[e] > 0) gapc[e]--;
            end else begin
                wr_valid[e] = 1'b0;
                if (act[e] && rbit[e] < 16 * cnt[e])
                    drive_rxd[drv[e]] = wds[e][rbit[e]/16][15 - rbit[e] % 16];
            end
        end
    endtask

    task automatic update_model();
        for (int e = 0; e < 2; e++) begin
            if (!act[e]) continue;
            if (isw[e]) begin
                lastf[e] = (epos[e] == 1) && !acc[e] && (widx[e] == cnt[e]);
                if (acc[e]) begin
                    eword[e] = wds[e][widx[e]];
                    epos[e] = 16;
                    widx[e]++;
                end else if (epos[e] > 0) begin
                    epos[e]--;
                end
            end else begin
                rbit[e]++;
            end
        end
    endtask

    task automatic run_xfers();
        @(posedge clk);
        @(negedge clk);
        cmd_start = '0;
        cmd_drive = ~cmd_drive;   // R6: later command changes must not matter
        cmd_write = ~cmd_write;
        cmd_words = '1;
        for (int cyc = 0; cyc < 400 && (act[0] || act[1]); cyc++) begin
            observe_and_drive();
            @(posedge clk);
            update_model();
            @(negedge clk);
        end
        if (act[0] || act[1]) chk("R5 transfer ended", 0, 1);
        act[0] = 0; act[1] = 0;
        wr_valid = '0; drive_rxd = '0;
        cmd_drive = '0; cmd_write = '0; cmd_words = '0;
    endtask

    task automatic pulse_start();
        @(posedge clk);
        @(negedge clk);
        cmd_start = '0;
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1: reset state
        chk("R1 busy", xfer_busy, 0);
        chk("R1 done", xfer_done, 0);
        chk("R1 err", xfer_err, 0);
        chk("R1 ready", wr_ready, 0);
        chk("R1 rvalid", rd_valid, 0);
        chk("R1 lines", drive_txd, 0);

        // Single-engine sweep over engine, drive, direction; gap on drive 2.
        for (int e = 0; e < 2; e++)
            for (int d = 0; d < 4; d++)
                for (int w = 0; w < 2; w++) begin
                    launch(e, w[0], d, 1 + (d % 3), (d == 2) ? 20 : 0, e * 8 + d * 2 + w);
                    run_xfers();
                end

        // R12: concurrent transfers on every ordered pair of distinct drives.
        for (int d0 = 0; d0 < 4; d0++)
            for (int d1 = 0; d1 < 4; d1++) begin
                if (d0 == d1) continue;
                launch(0, 1'b1, d0, 2, 0, 40 + d0 * 4 + d1);
                launch(1, d1[0], d1, 2, 0, 70 + d0 * 4 + d1);
                run_xfers();
            end

        // R9: simultaneous starts on the same drive.
        for (int d = 0; d < 4; d++) begin
            do_reset();
            cmd_start = 2'b11;
            cmd_drive = {2'(d), 2'(d)};
            cmd_write = 2'b01;
            cmd_words = {8'd1, 8'd1};
            pulse_start();
            chk("R9 err engine1 only", xfer_err, 2'b10);
            chk("R9 busy engine0 only", xfer_busy, 2'b01);
            @(negedge clk);
            chk("R8 err one cycle", xfer_err, 0);
        end

        // R8 / R11: drive held by busy engine, restart of busy engine.
        do_reset();
        cmd_start = 2'b01; cmd_drive = 4'b0001; cmd_write = 2'b01; cmd_words = 16'h0101;
        pulse_start();
        chk("R8 engine0 busy", xfer_busy[0], 1);
        cmd_start = 2'b10; cmd_drive = 4'b0101; cmd_write = 2'b11;
        pulse_start();
        chk("R8 refused err", xfer_err[1], 1);
        chk("R8 refused idle", xfer_busy[1], 0);
        cmd_start = 2'b01; cmd_drive = 4'b0010; cmd_write = 2'b00;
        pulse_start();
        chk("R11 no err", xfer_err[0], 0);
        chk("R11 still busy", xfer_busy[0], 1);
        wr_valid = 2'b01; wr_data = 32'h0000_8001;
        @(posedge clk);
        @(negedge clk);
        wr_valid = '0;
        chk("R11 original drive", drive_txd[1], 1);
        chk("R11 new drive silent", drive_txd[2], 0);

        // R10: zero word count refused.
        do_reset();
        cmd_start = 2'b01; cmd_drive = 4'b0011; cmd_write = 2'b01; cmd_words = 16'h0000;
        pulse_start();
        chk("R10 err", xfer_err[0], 1);
        chk("R10 idle", xfer_busy[0], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule